// File: doc/BRIEF.md
# Interrupt Priority Arbiter

This block picks the interrupt a hart should take. Each time the pipeline raises an evaluation request, the arbiter looks at the pending-interrupt lines, the delegation mask, the current privilege level, the two global enable bits and the debug-cause field. If an interrupt can be taken, it returns the number of the winning line.

Lines that stay at machine level are weighed first. Their enable depends on the current privilege. Delegated lines compete only when no machine-level line is enabled. Among the enabled lines the arbiter looks at four groups in a fixed order: lines above 11, then the external lines, then the software lines, then the timer lines. Inside the winning group the lowest-numbered line wins.

The result is registered. A one-cycle take strobe and an XLEN-wide cause word appear on the cycle after the request. The cause word has its top bit set and the line number in its low bits. The block does not enter the trap, write any control register or compute a vector.

Top module: `irq_priority_arbiter`

## Requirements
- R1: After a synchronous reset, `take_o` is 0 and `cause_o` is all zeros.
- R2: `take_o` rises only on the clock edge that samples `eval_req_i` high with a winner present, and it stays high for that one cycle only.
- R3: A line that is not delegated (its `deleg_i` bit is 0) is enabled when `priv_i` is 0 (user) or 1 (supervisor). It is also enabled when `priv_i` is 3 (machine) and `mie_i` is 1. In machine mode with `mie_i` at 0, nothing is taken.
- R4: Delegated lines are considered only when no non-delegated line is enabled. Delegated lines are enabled when `priv_i` is 0, or when `priv_i` is 1 and `sie_i` is 1.
- R5: While `dbg_cause_i` is nonzero, no interrupt is taken.
- R6: The groups rank as follows: lines 12 and up first, then lines 9 and 11, then lines 1 and 3, then lines 5 and 7.
- R7: Inside the winning group, the lowest-numbered enabled line is chosen.
- R8: On a take, `cause_o` has bit XLEN-1 set, the chosen line number in bits IDXW-1:0, and zeros in all bits between.
- R9: When no enabled candidate exists, or no request is made, `take_o` stays 0 and `cause_o` keeps its previous value.
- R10: Lines 0, 2, 4, 6, 8 and 10 belong to no group and never win, even when they are pending and enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| eval_req_i | input | 1 | Evaluate the inputs on this edge |
| pend_i | input | NIRQ | Pending interrupt lines |
| deleg_i | input | NIRQ | Delegation mask, 1 = delegated to supervisor |
| priv_i | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| mie_i | input | 1 | Machine global interrupt enable |
| sie_i | input | 1 | Supervisor global interrupt enable |
| dbg_cause_i | input | 3 | Debug cause; nonzero means the hart is in debug mode |
| take_o | output | 1 | One-cycle take strobe |
| cause_o | output | XLEN | Interrupt flag and chosen line number |

## Verification
Two things can land in the same evaluation. The first is a delegated line and a non-delegated line pending together. The second is a higher group and a lower group pending together. The bench drives these pairs under each privilege and enable setting, for example a supervisor software line delegated next to a machine timer line while in supervisor mode. It checks that the non-delegated line and the higher group win. It also sets a nonzero debug cause in the same cycle as a strong pending line and checks that nothing is taken. A scoreboard model built from the rules predicts every strobe and cause word, over directed and random vectors.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  typedef enum logic [1:0] {
    PRIV_USER  = 2'd0,
    PRIV_SUPV  = 2'd1,
    PRIV_RSVD  = 2'd2,
    PRIV_MACH  = 2'd3
  } priv_e;

  // Fixed line positions of the standard groups (decoded by neighbours).
  localparam int SOFT_S_BIT  = 1;
  localparam int SOFT_M_BIT  = 3;
  localparam int TIMER_S_BIT = 5;
  localparam int TIMER_M_BIT = 7;
  localparam int EXT_S_BIT   = 9;
  localparam int EXT_M_BIT   = 11;
endpackage

// File: rtl/irq_enable_filter.sv
module irq_enable_filter
  import irq_arb_pkg::*;
#(
  parameter int NIRQ = 16
) (
  input  logic [NIRQ-1:0] pend_i,
  input  logic [NIRQ-1:0] deleg_i,
  input  logic [1:0]      priv_i,
  input  logic            mie_i,
  input  logic            sie_i,
  output logic [NIRQ-1:0] cand_o
);
  priv_e       lvl;
  logic        mach_ok;
  logic        supv_ok;
  logic [NIRQ-1:0] mach_cand;
  logic [NIRQ-1:0] supv_cand;

  assign lvl = priv_e'(priv_i);

  always_comb begin
    mach_ok = (lvl != PRIV_MACH) || mie_i;
    supv_ok = (lvl == PRIV_USER) || ((lvl == PRIV_SUPV) && sie_i);
    mach_cand = mach_ok ? (pend_i & ~deleg_i) : '0;
    supv_cand = supv_ok ? (pend_i & deleg_i) : '0;
    // Machine-level candidates shadow every delegated one.
    cand_o = (|mach_cand) ? mach_cand : supv_cand;
  end
endmodule

// File: rtl/irq_group_select.sv
module irq_group_select
  import irq_arb_pkg::*;
#(
  parameter int NIRQ = 16
) (
  input  logic [NIRQ-1:0] cand_i,
  output logic [NIRQ-1:0] grp_o
);
  logic [NIRQ-1:0] custom_m;
  logic [NIRQ-1:0] ext_m;
  logic [NIRQ-1:0] soft_m;
  logic [NIRQ-1:0] timer_m;

  for (genvar b = 0; b < NIRQ; b++) begin : g_mask
    assign custom_m[b] = (b > EXT_M_BIT);
    assign ext_m[b]    = (b == EXT_S_BIT)   || (b == EXT_M_BIT);
    assign soft_m[b]   = (b == SOFT_S_BIT)  || (b == SOFT_M_BIT);
    assign timer_m[b]  = (b == TIMER_S_BIT) || (b == TIMER_M_BIT);
  end

  always_comb begin
    if (|(cand_i & custom_m))     grp_o = cand_i & custom_m;
    else if (|(cand_i & ext_m))   grp_o = cand_i & ext_m;
    else if (|(cand_i & soft_m))  grp_o = cand_i & soft_m;
    else if (|(cand_i & timer_m)) grp_o = cand_i & timer_m;
    else                          grp_o = '0;
  end
endmodule

// File: rtl/irq_lowbit_find.sv
module irq_lowbit_find #(
  parameter int NIRQ = 16,
  parameter int IDXW = $clog2(NIRQ)
) (
  input  logic [NIRQ-1:0] vec_i,
  output logic [IDXW-1:0] idx_o,
  output logic            found_o
);
  always_comb begin
    idx_o   = '0;
    found_o = 1'b0;
    for (int b = NIRQ - 1; b >= 0; b--) begin
      if (vec_i[b]) begin
        idx_o   = IDXW'(b);
        found_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_priority_arbiter.sv
module irq_priority_arbiter #(
  parameter int XLEN = 64,
  parameter int NIRQ = 16,
  parameter int DCW  = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            eval_req_i,
  input  logic [NIRQ-1:0] pend_i,
  input  logic [NIRQ-1:0] deleg_i,
  input  logic [1:0]      priv_i,
  input  logic            mie_i,
  input  logic            sie_i,
  input  logic [DCW-1:0]  dbg_cause_i,
  output logic            take_o,
  output logic [XLEN-1:0] cause_o
);
  localparam int IDXW = $clog2(NIRQ);
  localparam int PADW = XLEN - 1 - IDXW;

  logic [NIRQ-1:0] cand;
  logic [NIRQ-1:0] grp;
  logic [IDXW-1:0] win_idx;
  logic            win_found;
  logic            fire;

  irq_enable_filter #(.NIRQ(NIRQ)) u_filter (
    .pend_i  (pend_i),
    .deleg_i (deleg_i),
    .priv_i  (priv_i),
    .mie_i   (mie_i),
    .sie_i   (sie_i),
    .cand_o  (cand)
  );

  irq_group_select #(.NIRQ(NIRQ)) u_group (
    .cand_i (cand),
    .grp_o  (grp)
  );

  irq_lowbit_find #(.NIRQ(NIRQ), .IDXW(IDXW)) u_find (
    .vec_i   (grp),
    .idx_o   (win_idx),
    .found_o (win_found)
  );

  assign fire = eval_req_i && win_found && (dbg_cause_i == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      take_o  <= 1'b0;
      cause_o <= '0;
    end else begin
      take_o <= fire;
      if (fire) cause_o <= {1'b1, {PADW{1'b0}}, win_idx};
    end
  end

  assert_strobe_needs_request_R2: assert property (@(posedge clk) disable iff (rst)
    take_o |-> $past(eval_req_i));

  assert_machine_gate_R3: assert property (@(posedge clk) disable iff (rst)
    $past(priv_i == 2'd3 && !mie_i) |-> !take_o);

  assert_debug_blocks_R5: assert property (@(posedge clk) disable iff (rst)
    $past(dbg_cause_i != '0) |-> !take_o);

  assert_chosen_was_pending_R7: assert property (@(posedge clk) disable iff (rst)
    take_o |-> |($past(pend_i) & (NIRQ'(1) << cause_o[IDXW-1:0])));

  assert_cause_format_R8: assert property (@(posedge clk) disable iff (rst)
    take_o |-> (cause_o[XLEN-1] && (cause_o[XLEN-2:IDXW] == '0)));

  assert_hold_when_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !take_o |-> $stable(cause_o));
endmodule

// File: tb/test_irq_priority_arbiter.sv
`timescale 1ns/1ps
module test_irq_priority_arbiter;
  localparam int XLEN = 64;
  localparam int NIRQ = 16;
  localparam int IDXW = 4;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            eval_req = 1'b0;
  logic [NIRQ-1:0] pend = '0;
  logic [NIRQ-1:0] deleg = '0;
  logic [1:0]      priv = 2'd3;
  logic            mie = 1'b0;
  logic            sie = 1'b0;
  logic [2:0]      dbgc = '0;
  logic            take;
  logic [XLEN-1:0] cause;

  always #4 clk = ~clk;

  irq_priority_arbiter #(.XLEN(XLEN), .NIRQ(NIRQ), .DCW(3)) i_irq_priority_arbiter (
    .clk(clk), .rst(rst), .eval_req_i(eval_req), .pend_i(pend), .deleg_i(deleg),
    .priv_i(priv), .mie_i(mie), .sie_i(sie), .dbg_cause_i(dbgc),
    .take_o(take), .cause_o(cause)
  );

  typedef struct packed {
    logic [31:0]     due;
    logic            tk;
    logic [XLEN-1:0] cs;
  } item_t;

  item_t  exp_q[$];
  string  tag_q[$];
  int     checks = 0;
  int     fails  = 0;
  int     cyc    = 0;
  logic [XLEN-1:0] last_cause = '0;
  bit     done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // Reference built from the rules: returns the winning line or -1.
  function automatic int model(input logic [NIRQ-1:0] p, d, input logic [1:0] pv,
                               input logic me, se, input logic [2:0] dc);
    logic [NIRQ-1:0] c;
    int order[6] = '{9, 11, 1, 3, 5, 7};
    bit m_ok = (pv != 2'd3) || me;
    bit s_ok = (pv == 2'd0) || (pv == 2'd1 && se);
    if (dc != 0) return -1;
    c = m_ok ? (p & ~d) : '0;
    if (c == 0) c = s_ok ? (p & d) : '0;
    for (int i = 12; i < NIRQ; i++) if (c[i]) return i;
    for (int k = 0; k < 6; k++) begin
      // each group pair is listed low line first
      if (k % 2 == 0 && (c[order[k]] || c[order[k+1]]))
        return c[order[k]] ? order[k] : order[k+1];
    end
    return -1;
  endfunction

  task automatic drive(input logic [NIRQ-1:0] p, d, input logic [1:0] pv,
                       input logic me, se, input logic [2:0] dc, input logic rq,
                       input string tag);
    item_t it;
    int w;
    @(negedge clk);
    pend = p; deleg = d; priv = pv; mie = me; sie = se; dbgc = dc; eval_req = rq;
    w = model(p, d, pv, me, se, dc);
    it.due = cyc + 1;
    it.tk  = rq && (w >= 0);
    if (it.tk) last_cause = {1'b1, {(XLEN-1-IDXW){1'b0}}, IDXW'(w)};
    it.cs  = last_cause;
    exp_q.push_back(it);
    tag_q.push_back(tag);
  endtask

  always @(negedge clk) begin
    while (exp_q.size() > 0 && exp_q[0].due <= cyc) begin
      item_t it;
      string tg;
      it = exp_q.pop_front();
      tg = tag_q.pop_front();
      checks++;
      if (take !== it.tk || cause !== it.cs) begin
        fails++;
        $display("FAIL %s: take=%0b cause=%h expected take=%0b cause=%h",
                 tg, take, cause, it.tk, it.cs);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    checks++;
    if (take !== 1'b0 || cause !== '0) begin
      fails++;
      $display("FAIL R1 reset: take=%0b cause=%h expected take=0 cause=0", take, cause);
    end
    drive(16'h0080, 16'h0000, 2'd0, 0, 0, 0, 1, "R2 R3 user mode machine timer");
    drive(16'h0080, 16'h0000, 2'd0, 0, 0, 0, 0, "R2 R9 no request no strobe");
    drive(16'h0008, 16'h0000, 2'd3, 0, 0, 0, 1, "R3 machine mode mie off");
    drive(16'h0008, 16'h0000, 2'd3, 1, 0, 0, 1, "R3 machine mode mie on");
    drive(16'h0082, 16'h0002, 2'd1, 0, 1, 0, 1, "R4 delegated loses to machine line");
    drive(16'h0002, 16'h0002, 2'd1, 0, 1, 0, 1, "R4 delegated taken in supervisor");
    drive(16'h0002, 16'h0002, 2'd1, 1, 0, 0, 1, "R4 delegated blocked sie off");
    drive(16'h0002, 16'h0002, 2'd3, 1, 1, 0, 1, "R4 delegated blocked in machine");
    drive(16'h0020, 16'h0020, 2'd0, 0, 0, 0, 1, "R4 delegated taken in user");
    drive(16'h0800, 16'h0000, 2'd0, 1, 1, 3, 1, "R5 debug mode blocks");
    drive(16'h2200, 16'h0000, 2'd0, 0, 0, 0, 1, "R6 custom beats external");
    drive(16'h0808, 16'h0000, 2'd0, 0, 0, 0, 1, "R6 external beats software");
    drive(16'h0028, 16'h0000, 2'd0, 0, 0, 0, 1, "R6 software beats timer");
    drive(16'h0a00, 16'h0000, 2'd0, 0, 0, 0, 1, "R7 R8 lowest external line");
    drive(16'h9000, 16'h0000, 2'd0, 0, 0, 0, 1, "R7 R8 lowest custom line");
    drive(16'h0555, 16'h0000, 2'd0, 1, 1, 0, 1, "R10 ungrouped lines never win");
    drive(16'h0000, 16'h0000, 2'd0, 1, 1, 0, 1, "R9 nothing pending holds cause");
    drive(16'h0080, 16'h0000, 2'd0, 0, 0, 0, 1, "R2 back-to-back request one");
    drive(16'h0020, 16'h0000, 2'd0, 0, 0, 0, 1, "R2 back-to-back request two");
    for (int n = 0; n < 400; n++) begin
      logic [2:0] dc;
      dc = ($urandom % 5 == 0) ? 3'($urandom) : 3'd0;
      drive(NIRQ'($urandom), NIRQ'($urandom), 2'($urandom), 1'($urandom),
            1'($urandom), dc, 1'($urandom % 4 != 0), "R3 R4 R6 R7 R9 random vector");
    end
    drive('0, '0, 2'd3, 0, 0, 0, 0, "R9 final idle");
    repeat (3) @(negedge clk);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule